// File: doc/BRIEF.md
# Memory-Mapped Terminal Register Interface

This block sits on a processor's load/store port and gives software two byte channels. One channel takes characters in from a keyboard-side source. The other passes characters out to a display-side sink. Each direction has a small control word and a data word. The control word holds a ready flag and an interrupt enable. The data word carries one character in its low byte.

Software can work in two ways. It can poll the ready flags, or it can set the enables and wait for the interrupt request. The ready flags change as a side effect of data accesses. Reading the received character empties the receive side. Writing a character makes the transmit side busy until the sink takes the byte.

A sticky overrun flag records that a received byte was replaced before software read it. Reading the receive control word clears that flag.

Top module: `term_mmio`

## Requirements
- R1: After reset, receive ready, overrun and both interrupt enables are 0, transmit ready is 1, `txValid` and `irq` are 0, and `busRdata` is 0.
- R2: Byte offsets in the low `ADDR_W` address bits select the registers: 0x0 receive control, 0x4 receive data, 0x8 transmit control, 0xC transmit data. Control word bit 0 is ready, bit 1 is interrupt enable and bit 2 is receive overrun. Read data appears on `busRdata` in the cycle after the read edge, reflects the state before that edge, and holds until the next read. Any other offset reads as zero and ignores writes.
- R3: A cycle with `rxValid` high loads `rxByte` and sets receive ready. A read of receive data returns that byte in bits 7:0 with all upper bits 0.
- R4: A read of receive data clears receive ready. If a new byte arrives in the same cycle, the new byte is loaded and ready stays 1.
- R5: A byte that arrives while receive ready is 1, and is not consumed by a data read in the same cycle, overwrites the stored byte and sets overrun (bit 2). A read of receive control returns the bit and then clears it.
- R6: A write to transmit data while transmit ready is 1 loads the low byte, clears transmit ready, and raises `txValid` with that byte on `txByte` from the next cycle.
- R7: `txValid` and `txByte` hold until a cycle with `txReady` high. After that edge, transmit ready is 1 and `txValid` is 0.
- R8: A write to transmit data while transmit ready is 0 is ignored, and `txByte` keeps the pending byte.
- R9: A control write changes only the interrupt enable (bit 1). Bits 0 and 2 of the written word are ignored.
- R10: `irq` is 1 whenever receive ready and receive enable are both 1, or transmit ready and transmit enable are both 1, and 0 otherwise.
- R11: A read of transmit data returns the last accepted transmit byte in bits 7:0 with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset within the block |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, one cycle after the read |
| rxValid | input | 1 | Receive source presents a byte |
| rxByte | input | CHAR_W | Received character |
| txValid | output | 1 | Transmit byte pending for the sink |
| txByte | output | CHAR_W | Pending transmit character |
| txReady | input | 1 | Sink accepts the pending byte |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is tried with three patterns. The first is a single byte followed by a read, which separates the set and clear of ready. The second is two bytes with no read between them, which must show overrun and the later byte. The third is a byte that arrives on the same edge as a data read, which tells a read that consumes the old byte from one that would drop the new one.

The transmit path is tried with several cases:
- a write while idle;
- a second write while busy, which must leave the pending byte untouched;
- a sink that stalls for several cycles before accepting the byte.

Control writes use all-ones and near-all-ones words, so that any leak into the ready or overrun bits is seen. The interrupt is observed for each direction with its enable on and off. Unaligned and unused offsets are read and written.

// File: rtl/term_pkg.sv
package term_pkg;
  localparam int RDY_BIT = 0;
  localparam int IE_BIT  = 1;
  localparam int OVR_BIT = 2;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_RXCTRL = 3'd1,
    SEL_RXDATA = 3'd2,
    SEL_TXCTRL = 3'd3,
    SEL_TXDATA = 3'd4
  } regSel_e;

  typedef struct packed {
    logic    rd;
    regSel_e rdSel;
    logic    rxDataRd;
    logic    rxCtrlRd;
    logic    rxCtrlWr;
    logic    txCtrlWr;
    logic    txDataWr;
  } strobe_t;
endpackage

// File: rtl/term_ctrl.sv
module term_ctrl
  import term_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           st
);
  localparam int IDX_LO = 2;

  logic    hiZero;
  logic    aligned;
  regSel_e hitSel;

  if (ADDR_W > 4) begin : g_hi
    assign hiZero = ~|busAddr[ADDR_W-1:4];
  end else begin : g_nohi
    assign hiZero = 1'b1;
  end

  assign aligned = (busAddr[IDX_LO-1:0] == '0) && hiZero;

  always_comb begin
    hitSel = SEL_NONE;
    if (aligned) begin
      unique case (busAddr[3:2])
        2'd0: hitSel = SEL_RXCTRL;
        2'd1: hitSel = SEL_RXDATA;
        2'd2: hitSel = SEL_TXCTRL;
        default: hitSel = SEL_TXDATA;
      endcase
    end
  end

  always_comb begin
    st          = '0;
    st.rd       = busSel && !busWe;
    st.rdSel    = (busSel && !busWe) ? hitSel : SEL_NONE;
    st.rxDataRd = busSel && !busWe && (hitSel == SEL_RXDATA);
    st.rxCtrlRd = busSel && !busWe && (hitSel == SEL_RXCTRL);
    st.rxCtrlWr = busSel && busWe && (hitSel == SEL_RXCTRL);
    st.txCtrlWr = busSel && busWe && (hitSel == SEL_TXCTRL);
    st.txDataWr = busSel && busWe && (hitSel == SEL_TXDATA);
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.rxDataRd, st.rxCtrlRd, st.rxCtrlWr, st.txCtrlWr, st.txDataWr}));

  // R2
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (st == '0));
endmodule

// File: rtl/term_dp.sv
module term_dp
  import term_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxByte,
  output logic              txValid,
  output logic [CHAR_W-1:0] txByte,
  input  logic              txReady,
  output logic              irq
);
  localparam int CTRL_W = 3;

  logic              rxRdy, rxIe, rxOvr;
  logic              txRdy, txIe;
  logic [CHAR_W-1:0] rxData, txData;
  logic              txTake;
  logic [DATA_W-1:0] rdMux;

  assign txTake = !txRdy && txReady;

  // receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxRdy  <= 1'b0;
      rxOvr  <= 1'b0;
      rxIe   <= 1'b0;
      rxData <= '0;
    end else begin
      if (rxValid) begin
        rxData <= rxByte;
        rxRdy  <= 1'b1;
      end else if (st.rxDataRd) begin
        rxRdy <= 1'b0;
      end
      if (rxValid && rxRdy && !st.rxDataRd) rxOvr <= 1'b1;
      else if (st.rxCtrlRd)                 rxOvr <= 1'b0;
      if (st.rxCtrlWr) rxIe <= busWdata[IE_BIT];
    end
  end

  // transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRdy  <= 1'b1;
      txIe   <= 1'b0;
      txData <= '0;
    end else begin
      if (st.txDataWr && txRdy) begin
        txData <= busWdata[CHAR_W-1:0];
        txRdy  <= 1'b0;
      end else if (txTake) begin
        txRdy <= 1'b1;
      end
      if (st.txCtrlWr) txIe <= busWdata[IE_BIT];
    end
  end

  assign txValid = !txRdy;
  assign txByte  = txData;
  assign irq     = (rxRdy && rxIe) || (txRdy && txIe);

  // read mux
  always_comb begin
    rdMux = '0;
    unique case (st.rdSel)
      SEL_RXCTRL: rdMux = DATA_W'({rxOvr, rxIe, rxRdy});
      SEL_RXDATA: rdMux = DATA_W'(rxData);
      SEL_TXCTRL: rdMux = DATA_W'({1'b0, txIe, txRdy});
      SEL_TXDATA: rdMux = DATA_W'(txData);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (st.rd) busRdata <= rdMux;
  end

  // R4
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxDataRd && !rxValid) |=> !rxRdy);

  // R3
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (rxRdy && rxData == $past(rxByte)));

  // R5
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxRdy && !st.rxDataRd) |=> rxOvr);

  // R6
  tx_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.txDataWr && txRdy) |=> txValid);

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

  // R7
  tx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txValid);

  // R10
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxIe && !st.rxCtrlWr) |=> irq);

  // R2
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rd && st.rdSel == SEL_NONE) |=> (busRdata == '0));

  initial begin
    ctrl_fits_chk: assert (CTRL_W <= DATA_W && CHAR_W <= DATA_W);
  end
endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import term_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxByte,
  output logic              txValid,
  output logic [CHAR_W-1:0] txByte,
  input  logic              txReady,
  output logic              irq
);
  strobe_t st;

  term_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .st(st)
  );

  term_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata),
    .busRdata(busRdata), .rxValid(rxValid), .rxByte(rxByte),
    .txValid(txValid), .txByte(txByte), .txReady(txReady), .irq(irq)
  );
endmodule

// File: tb/term_mmio_test.sv
module term_mmio_test;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CHAR_W = 8;
  localparam time CLK_P = 8ns;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0, busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              rxValid = 1'b0;
  logic [CHAR_W-1:0] rxByte = '0;
  logic              txValid;
  logic [CHAR_W-1:0] txByte;
  logic              txReady = 1'b0;
  logic              irq;

  int testCnt = 0;
  int failCnt = 0;
  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];

  always #(CLK_P/2) clk = ~clk;

  term_mmio #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxByte(rxByte), .txValid(txValid),
    .txByte(txByte), .txReady(txReady), .irq(irq)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values when the response appears
  initial begin
    forever begin
      @(posedge clk);
      if (busSel && !busWe) begin
        @(negedge clk);
        if (expQ.size() > 0) check(tagQ.pop_front(), busRdata, expQ.pop_front());
      end
    end
  end

  task automatic busRd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic rxSend(input logic [CHAR_W-1:0] b);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sinkTake();
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    testCnt++; failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 irq", DATA_W'(irq), 0);
    check("R1 txValid", DATA_W'(txValid), 0);
    check("R1 busRdata", busRdata, 0);
    busRd(4'h0, 32'h0, "R1 rx ctrl");
    busRd(4'h8, 32'h1, "R1 tx ctrl");

    // R3, R4
    rxSend(8'h41);
    busRd(4'h0, 32'h1, "R3 rx ready set");
    busRd(4'h4, 32'h41, "R3 rx data");
    busRd(4'h0, 32'h0, "R4 rx ready cleared");

    // R5
    rxSend(8'h10);
    rxSend(8'h22);
    busRd(4'h0, 32'h5, "R5 overrun seen");
    busRd(4'h0, 32'h1, "R5 overrun cleared");
    busRd(4'h4, 32'h22, "R5 newer byte kept");

    // R4 same-edge arrival and read
    rxSend(8'h33);
    expQ.push_back(32'h33); tagQ.push_back("R4 old byte read");
    busSel = 1'b1; busWe = 1'b0; busAddr = 4'h4; rxValid = 1'b1; rxByte = 8'h44;
    @(negedge clk);
    busSel = 1'b0; rxValid = 1'b0;
    busRd(4'h0, 32'h1, "R4 ready kept, no overrun");
    busRd(4'h4, 32'h44, "R4 new byte");
    busRd(4'h0, 32'h0, "R4 empty");

    // R9, R10 receive enable
    busWr(4'h0, 32'hFFFF_FFFF);
    busRd(4'h0, 32'h2, "R9 rx ctrl only enable");
    check("R10 irq idle", DATA_W'(irq), 0);
    rxSend(8'h55);
    check("R10 rx irq", DATA_W'(irq), 1);
    busRd(4'h4, 32'h55, "R3 rx data 55");
    check("R10 rx irq drop", DATA_W'(irq), 0);
    busWr(4'h0, 32'h0);

    // R6, R8, R11, R7
    busWr(4'hC, 32'hABCD_EF61);
    check("R6 txValid", DATA_W'(txValid), 1);
    check("R6 txByte", DATA_W'(txByte), 32'h61);
    busRd(4'h8, 32'h0, "R6 tx busy");
    busWr(4'hC, 32'h62);
    check("R8 txByte kept", DATA_W'(txByte), 32'h61);
    busRd(4'hC, 32'h61, "R11 tx data read");
    repeat (3) @(negedge clk);
    check("R7 stall holds", DATA_W'(txValid), 1);
    sinkTake();
    check("R7 txValid drop", DATA_W'(txValid), 0);
    busRd(4'h8, 32'h1, "R7 tx ready back");

    // R10 transmit enable, R9
    busWr(4'h8, 32'h2);
    check("R10 tx irq", DATA_W'(irq), 1);
    busRd(4'h8, 32'h3, "R9 tx ctrl");
    busWr(4'hC, 32'h70);
    check("R10 tx irq busy", DATA_W'(irq), 0);
    sinkTake();
    check("R10 tx irq back", DATA_W'(irq), 1);
    busWr(4'h8, 32'hFFFF_FFFD);
    busRd(4'h8, 32'h1, "R9 tx enable cleared, ready kept");
    check("R10 irq masked", DATA_W'(irq), 0);
    busRd(4'hC, 32'h70, "R11 last byte");

    // R2 undefined offsets
    busWr(4'h6, 32'hFFFF_FFFF);
    busWr(4'h1, 32'hFFFF_FFFF);
    busRd(4'h0, 32'h0, "R2 undefined write ignored");
    busRd(4'h2, 32'h0, "R2 unaligned reads zero");
    busRd(4'hE, 32'h0, "R2 offset E reads zero");
    repeat (2) @(negedge clk);
    check("R2 read data holds", busRdata, 0);

    repeat (3) @(negedge clk);
    check("queue drained", DATA_W'(expQ.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule